// File: doc/BRIEF.md
# Double-Buffered Nibble-Addressable Converter Code Register

This block is the digital front end of a 12-bit digital-to-analog converter. A host writes the 12-bit data bus into a staging rank of three 4-bit holding registers, each chosen by its own active-low select. A second, 12-bit output rank then takes the assembled word and drives the converter code. Both ranks are enabled only while the shared active-low write strobe is low. A host on a 4-, 8-, 12- or 16-bit bus can build a word piece by piece and then move it to the output in one step. The step that transfers the word may also write the last nibble, and the output then never shows a half-updated value.

Control lines are sampled on the rising clock edge, so each rank behaves as a clocked model of a level-sensitive latch. The decoder names four operations. IDLE: the strobe is high, or no rank is selected. STAGE: one or more nibbles are written. COMMIT: the staged word moves to the output. STAGE_COMMIT: nibbles are written and the output is loaded in the same edge, using the nibble values being written. A static format input chooses straight binary or two's-complement input. In two's-complement mode bit 11 is inverted as it enters the upper holding register, which gives offset-binary codes where 0x800 is mid-scale. A registered pulse marks every cycle in which the output code takes a new value.

Top module: `nibble_dac_reg`

## Requirements
- R1: A synchronous active-high reset clears both ranks to 0x000 and clears the update pulse. A transfer issued right after reset therefore drives 0x000.
- R2: At a rising edge with the write strobe low, the upper select writes bus bits 11..8 into holding bits 11..8, the middle select writes bits 7..4, and the lower select writes bits 3..0. An unselected nibble keeps its value.
- R3: At a rising edge with the write strobe high, neither rank changes, whatever the selects, the load signal and the bus carry.
- R4: At a rising edge with both the write strobe and the load signal low, the output code takes the holding word. With the load signal high, the output code keeps its value.
- R5: When a nibble write and a transfer fall in the same edge, the output code equals the previously held nibbles merged with the newly written nibble. No mixed intermediate code appears.
- R6: With the strobe, all three selects and the load signal low, the bus value appears on the output code one clock after the edge. In straight-binary mode it is unchanged.
- R7: With the format input high, bit 11 of the bus is inverted as it is stored, so two's-complement 0x000, 0x7FF and 0x800 become 0x800, 0xFFF and 0x000. With the format input low, no bit is altered.
- R8: The update output is high for exactly the cycle in which the output code differs from its value one cycle earlier. It stays low after a transfer that reloads the same value.
- R9: A mid-scale step between 0x7FF and 0x800, staged over several writes, reaches the output as one change with one update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low, qualifies every rank |
| sel_hi_n | input | 1 | Select for the holding nibble of bits 11..8, active low |
| sel_mid_n | input | 1 | Select for the holding nibble of bits 7..4, active low |
| sel_lo_n | input | 1 | Select for the holding nibble of bits 3..0, active low |
| load_n | input | 1 | Transfer holding word to output rank, active low |
| fmt_twos | input | 1 | 1 = two's-complement input (bit 11 inverted on storage), 0 = straight binary |
| bus_in | input | 12 | Data bus |
| code_out | output | 12 | Converter code from the output rank |
| code_upd | output | 1 | One-cycle pulse, high when code_out has just changed |

## Verification
The hard case is a nibble write and an output transfer in the same edge (STAGE_COMMIT). The output must then pick up the nibble on the bus, not the stale one in the holding register. The bench first stages the upper nibbles in separate writes. It then issues the last nibble together with the load signal, including the 0x7FF to 0x800 mid-scale step. The scoreboard model expects the merged word, with a single update pulse, on the first cycle after that edge. It also expects the output unchanged and no pulse on every earlier partial write.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

    localparam int NIB_W_DEF   = 4;
    localparam int NIBBLES_DEF = 3;

    typedef enum logic [1:0] {
        OP_IDLE         = 2'd0,
        OP_STAGE        = 2'd1,
        OP_COMMIT       = 2'd2,
        OP_STAGE_COMMIT = 2'd3
    } op_e;

endpackage

// File: rtl/dacreg_ctrl.sv
module dacreg_ctrl
    import dacreg_pkg::*;
#(
    parameter int NIBBLES = NIBBLES_DEF
) (
    input  logic               wr_n,
    input  logic [NIBBLES-1:0] sel_n,
    input  logic               load_n,
    output logic [NIBBLES-1:0] nib_en,
    output logic               commit
);

    op_e  op;
    logic stage_req;
    logic commit_req;

    always_comb begin
        stage_req  = !wr_n && (sel_n != {NIBBLES{1'b1}});
        commit_req = !wr_n && !load_n;
        unique case ({commit_req, stage_req})
            2'b00:   op = OP_IDLE;
            2'b01:   op = OP_STAGE;
            2'b10:   op = OP_COMMIT;
            2'b11:   op = OP_STAGE_COMMIT;
            default: op = OP_IDLE;
        endcase
    end

    always_comb begin
        nib_en = '0;
        commit = 1'b0;
        unique case (op)
            OP_IDLE: ;
            OP_STAGE:        nib_en = ~sel_n;
            OP_COMMIT:       commit = 1'b1;
            OP_STAGE_COMMIT: begin
                nib_en = ~sel_n;
                commit = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dacreg_hold_bank.sv
module dacreg_hold_bank
    import dacreg_pkg::*;
#(
    parameter int NIB_W   = NIB_W_DEF,
    parameter int NIBBLES = NIBBLES_DEF,
    localparam int WORD_W = NIB_W * NIBBLES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NIBBLES-1:0] nib_en,
    input  logic               fmt_twos,
    input  logic [WORD_W-1:0]  bus_in,
    output logic [WORD_W-1:0]  hold_q,
    output logic [WORD_W-1:0]  hold_d
);

    logic [WORD_W-1:0] fmt_word;

    always_comb fmt_word = bus_in ^ {fmt_twos, {(WORD_W-1){1'b0}}};

    for (genvar i = 0; i < NIBBLES; i++) begin : g_nib
        always_comb begin
            hold_d[i*NIB_W +: NIB_W] = nib_en[i] ? fmt_word[i*NIB_W +: NIB_W]
                                                 : hold_q[i*NIB_W +: NIB_W];
        end

        always_ff @(posedge clk) begin
            if (rst) hold_q[i*NIB_W +: NIB_W] <= '0;
            else     hold_q[i*NIB_W +: NIB_W] <= hold_d[i*NIB_W +: NIB_W];
        end

        // R2 R3
        nib_keep_chk: assert property (@(posedge clk) disable iff (rst)
            !nib_en[i] |=> $stable(hold_q[i*NIB_W +: NIB_W]));
    end

endmodule

// File: rtl/dacreg_out_rank.sv
module dacreg_out_rank
    import dacreg_pkg::*;
#(
    parameter int WORD_W = NIB_W_DEF * NIBBLES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [WORD_W-1:0] hold_d,
    output logic [WORD_W-1:0] code_q,
    output logic              upd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= commit && (hold_d != code_q);
            if (commit) code_q <= hold_d;
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R4
    out_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(code_q));

    // R8
    upd_match_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (upd_q == (code_q != $past(code_q))));

endmodule

// File: rtl/nibble_dac_reg.sv
module nibble_dac_reg
    import dacreg_pkg::*;
#(
    parameter int NIB_W = NIB_W_DEF,
    localparam int NIBBLES = NIBBLES_DEF,
    localparam int WORD_W  = NIB_W * NIBBLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              sel_hi_n,
    input  logic              sel_mid_n,
    input  logic              sel_lo_n,
    input  logic              load_n,
    input  logic              fmt_twos,
    input  logic [WORD_W-1:0] bus_in,
    output logic [WORD_W-1:0] code_out,
    output logic              code_upd
);

    logic [NIBBLES-1:0] sel_n;
    logic [NIBBLES-1:0] nib_en;
    logic               commit;
    logic [WORD_W-1:0]  hold_q;
    logic [WORD_W-1:0]  hold_d;

    always_comb sel_n = {sel_hi_n, sel_mid_n, sel_lo_n};

    dacreg_ctrl #(.NIBBLES(NIBBLES)) u_ctrl (
        .wr_n   (wr_n),
        .sel_n  (sel_n),
        .load_n (load_n),
        .nib_en (nib_en),
        .commit (commit)
    );

    dacreg_hold_bank #(.NIB_W(NIB_W), .NIBBLES(NIBBLES)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .nib_en   (nib_en),
        .fmt_twos (fmt_twos),
        .bus_in   (bus_in),
        .hold_q   (hold_q),
        .hold_d   (hold_d)
    );

    dacreg_out_rank #(.WORD_W(WORD_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .hold_d (hold_d),
        .code_q (code_out),
        .upd_q  (code_upd)
    );

    // R3
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        wr_n |=> ($stable(code_out) && $stable(hold_q)));

    // R4 R5
    transfer_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !load_n) |=> (code_out == hold_q));

endmodule

// File: tb/tb_nibble_dac_reg.sv
module tb_nibble_dac_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_n = 1'b1, sel_hi_n = 1'b1, sel_mid_n = 1'b1, sel_lo_n = 1'b1;
    logic        load_n = 1'b1, fmt = 1'b0;
    logic [11:0] bus_in = '0;
    logic [11:0] code_out;
    logic        code_upd;

    always #10 clk = ~clk;

    nibble_dac_reg dut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .sel_hi_n(sel_hi_n),
        .sel_mid_n(sel_mid_n), .sel_lo_n(sel_lo_n), .load_n(load_n),
        .fmt_twos(fmt), .bus_in(bus_in), .code_out(code_out), .code_upd(code_upd)
    );

    typedef struct {
        logic [11:0] code;
        logic        upd;
        int          due;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    logic [11:0] m_hold = '0;
    logic [11:0] m_out = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected items as the design produces them
    always @(negedge clk) begin
        #1;
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (code_out !== e.code || code_upd !== e.upd) begin
                n_bad++;
                $display("FAIL %s: code=%h upd=%b expected code=%h upd=%b",
                         e.tag, code_out, code_upd, e.code, e.upd);
            end
        end
    end

    // driver: drives one edge of controls and pushes the model's result
    task automatic apply(input logic w, input logic a, input logic b, input logic c,
                         input logic l, input logic [11:0] d, input string tag);
        logic [11:0] nh, fd, no;
        exp_t e;
        wr_n = w; sel_hi_n = a; sel_mid_n = b; sel_lo_n = c; load_n = l; bus_in = d;
        fd = d ^ {fmt, 11'b0};
        nh = m_hold;
        if (!w && !a) nh[11:8] = fd[11:8];
        if (!w && !b) nh[7:4]  = fd[7:4];
        if (!w && !c) nh[3:0]  = fd[3:0];
        no = m_out;
        if (!w && !l) no = nh;
        e.code = no;
        e.upd  = (no != m_out);
        e.due  = cyc + 1;
        e.tag  = tag;
        sb.push_back(e);
        m_hold = nh;
        m_out  = no;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        apply(1, 1, 1, 1, 1, 12'h000, tag);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_vec++;
        if (code_out !== 12'h000 || code_upd !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: code=%h upd=%b expected code=000 upd=0", code_out, code_upd);
        end
        // R1: transfer of reset holding word
        apply(0, 1, 1, 1, 0, 12'hABC, "R1");

        // R2: nibble map, one nibble at a time, then transfer
        apply(0, 0, 1, 1, 1, 12'h5A3, "R2");
        apply(0, 1, 0, 1, 1, 12'hFCF, "R2");
        apply(0, 1, 1, 0, 1, 12'h129, "R2");
        apply(0, 1, 1, 1, 0, 12'h000, "R2");
        apply(0, 1, 0, 1, 0, 12'h0E0, "R2");

        // R3: strobe high blocks everything
        apply(1, 0, 0, 0, 0, 12'hFFF, "R3");
        apply(1, 0, 1, 0, 1, 12'h333, "R3");
        apply(0, 1, 1, 1, 0, 12'h000, "R3");

        // R4: load high keeps output; load low transfers
        apply(0, 0, 0, 1, 1, 12'h66F, "R4");
        idle("R4");
        apply(0, 1, 1, 1, 0, 12'h000, "R4");

        // R5: final nibble and transfer in the same edge
        apply(0, 0, 1, 1, 1, 12'h300, "R5");
        apply(0, 1, 0, 1, 1, 12'h0C0, "R5");
        apply(0, 1, 1, 0, 0, 12'h00D, "R5");
        apply(0, 0, 0, 1, 0, 12'h71F, "R5");

        // R6: all transparent
        apply(0, 0, 0, 0, 0, 12'h3C6, "R6");
        apply(0, 0, 0, 0, 0, 12'hFFF, "R6");
        idle("R6");

        // R8: same value reload gives no pulse
        apply(0, 1, 1, 1, 0, 12'h000, "R8");
        apply(0, 0, 0, 0, 0, 12'hFFF, "R8");
        apply(0, 0, 0, 0, 0, 12'h001, "R8");
        apply(0, 0, 0, 0, 0, 12'h002, "R8");

        // R9: 0x7FF -> 0x800 staged, single atomic change
        apply(0, 0, 0, 0, 0, 12'h7FF, "R9");
        apply(0, 0, 1, 1, 1, 12'h800, "R9");
        apply(0, 1, 0, 1, 1, 12'h000, "R9");
        apply(0, 1, 1, 0, 0, 12'h000, "R9");
        apply(0, 0, 1, 1, 1, 12'h700, "R9");
        apply(0, 1, 0, 1, 1, 12'h0F0, "R9");
        apply(0, 1, 1, 0, 0, 12'h00F, "R9");
        idle("R9");

        // R7: two's-complement format inverts bit 11 on storage
        fmt = 1'b1;
        apply(0, 0, 0, 0, 0, 12'h000, "R7");
        apply(0, 0, 0, 0, 0, 12'h7FF, "R7");
        apply(0, 0, 0, 0, 0, 12'h800, "R7");
        apply(0, 1, 0, 0, 0, 12'hFFF, "R7");
        fmt = 1'b0;
        apply(0, 0, 0, 0, 0, 12'h800, "R7");
        idle("R7");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run not finished, expected completion");
        summary();
    end

endmodule